// File: doc/BRIEF.md
# Gated Sensor Burst-Read Sequencer

This block steps a byte-oriented serial-bus master through a repeating read of a fixed run of consecutive sensor registers and files each returned byte into a small local RAM. After reset it sends one configuration write to the sensor. It then waits for its enable input. Each burst reads `BURST_LEN` registers, starting at `BASE_REG` and rising by one each time, and stores them at RAM addresses 0 upward in the order they arrive. When the last byte of a burst is stored, a level output inverts, so that an external counter or scope can measure the burst rate.

Two copies of this block can share a board. Each one drives its own bus master and takes enables that are complements of each other, so their bursts alternate. For that reason the enable is checked only when a burst is about to start. An enable that drops partway through a burst lets that burst run to the end. If the bus master reports a missing acknowledge, the burst is abandoned and the sequencer goes back to waiting for the enable.

Top module: `burst_read_seq`

## Requirements
- R1: While reset is held, `cmd_valid`, `ram_we` and `done_toggle` are low. The first command after reset is a write (`cmd_write`=1) of `CFG_VAL` to register `CFG_REG`.
- R2: If the configuration write's response has `rsp_ack_err`=1, the same configuration write is issued again. No read is issued until a configuration write succeeds.
- R3: A burst starts only from idle. The first read command is asserted in the cycle after a rising clock edge at which `en` was high. While `en` is low in idle, no command is issued.
- R4: A burst issues exactly `BURST_LEN` read commands (`cmd_write`=0). Their `cmd_reg` values are `BASE_REG`, `BASE_REG`+1, … in ascending order. Each new command is issued only after the response to the previous one.
- R5: A response with `rsp_ack_err`=0 to the k-th read of a burst (k counted from 0) produces, on the next clock, a single-cycle `ram_we` with `ram_addr`=k and `ram_wdata` equal to that response's `rsp_data`. Addresses at or above `BURST_LEN` are never written.
- R6: `done_toggle` inverts in the same cycle as the RAM write for address `BURST_LEN`-1, and at no other time.
- R7: If `en` is low at the edge where the last response of a burst is accepted, the burst still completes with its toggle. After that, no command is issued until `en` is high again.
- R8: A response with `rsp_ack_err`=1 to a read produces no RAM write and no toggle. The sequencer returns to idle, and the next burst starts again at `BASE_REG` and RAM address 0.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_write`, `cmd_reg` and `cmd_wdata` hold their values. After a handshake, `cmd_valid` is low on the next cycle.
- R10: A `rsp_valid` pulse that arrives when no command is outstanding is ignored: it causes no RAM write and does not change the state.
- R11: If `en` is high at the edge where a burst's last response is accepted, the next burst's first read command is asserted on the following cycle, without passing through idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Burst-start permission |
| cmd_valid | output | 1 | Command offered to the bus master |
| cmd_ready | input | 1 | Bus master accepts the command |
| cmd_write | output | 1 | 1 = register write, 0 = register read |
| cmd_reg | output | REG_W | Sensor register address |
| cmd_wdata | output | DATA_W | Byte to write (configuration only) |
| rsp_valid | input | 1 | Bus master transaction finished |
| rsp_ack_err | input | 1 | Transaction was not acknowledged |
| rsp_data | input | DATA_W | Byte read from the sensor |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | AW | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| done_toggle | output | 1 | Inverts once per completed burst |

## Verification
Two situations are hard to reach from the ports. One is an enable that falls while a burst is in flight. The other is an acknowledge failure at a chosen position inside a burst. Both depend on where the sequencer is in its burst, which the ports do not show directly. The bench's reference model follows the burst position from observed handshakes and responses. The stimulus waits on that position: it drops `en` right after the seventh read is accepted, and it flags the sixth read handshake so that the bus model answers it with an error. A one-cycle enable pulse in idle and a stray response while idle with `en` low complete the gating cases.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_CFG_ISSUE,
        ST_CFG_WAIT,
        ST_IDLE,
        ST_RD_ISSUE,
        ST_RD_WAIT
    } seq_state_e;

endpackage

// File: rtl/brs_fsm.sv
module brs_fsm
    import brs_pkg::*;
#(
    parameter int                  BURST_LEN = 14,
    parameter int                  IDXW      = 4,
    parameter int                  REG_W     = 8,
    parameter int                  DATA_W    = 8,
    parameter logic [REG_W-1:0]    BASE_REG  = 8'h3B,
    parameter bit                  CFG_EN    = 1'b1,
    parameter logic [REG_W-1:0]    CFG_REG   = 8'h6B,
    parameter logic [DATA_W-1:0]   CFG_VAL   = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [REG_W-1:0]  cmd_reg,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_ack_err,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              cap_valid,
    output logic [IDXW-1:0]   cap_idx,
    output logic [DATA_W-1:0] cap_byte,
    output logic              burst_end
);

    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(BURST_LEN - 1);

    typedef struct packed {
        seq_state_e       st;
        logic [IDXW-1:0]  idx;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        cmd_valid = 1'b0;
        cmd_write = 1'b0;
        cmd_reg   = '0;
        cmd_wdata = '0;
        cap_valid = 1'b0;
        cap_idx   = seq_q.idx;
        cap_byte  = rsp_data;
        burst_end = 1'b0;

        unique case (seq_q.st)
            ST_BOOT: begin
                seq_d.st = CFG_EN ? ST_CFG_ISSUE : ST_IDLE;
            end
            ST_CFG_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_write = 1'b1;
                cmd_reg   = CFG_REG;
                cmd_wdata = CFG_VAL;
                if (cmd_ready) seq_d.st = ST_CFG_WAIT;
            end
            ST_CFG_WAIT: begin
                if (rsp_valid) seq_d.st = rsp_ack_err ? ST_CFG_ISSUE : ST_IDLE;
            end
            ST_IDLE: begin
                seq_d.idx = '0;
                if (en) seq_d.st = ST_RD_ISSUE;
            end
            ST_RD_ISSUE: begin
                cmd_valid = 1'b1;
                cmd_reg   = BASE_REG + REG_W'(seq_q.idx);
                if (cmd_ready) seq_d.st = ST_RD_WAIT;
            end
            ST_RD_WAIT: begin
                if (rsp_valid) begin
                    if (rsp_ack_err) begin
                        seq_d.st  = ST_IDLE;
                        seq_d.idx = '0;
                    end else begin
                        cap_valid = 1'b1;
                        if (seq_q.idx == LAST_IDX) begin
                            burst_end = 1'b1;
                            seq_d.idx = '0;
                            seq_d.st  = en ? ST_RD_ISSUE : ST_IDLE;
                        end else begin
                            seq_d.idx = seq_q.idx + 1'b1;
                            seq_d.st  = ST_RD_ISSUE;
                        end
                    end
                end
            end
            default: begin
                seq_d.st  = ST_IDLE;
                seq_d.idx = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st  <= ST_BOOT;
            seq_q.idx <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

endmodule

// File: rtl/brs_ram_port.sv
module brs_ram_port #(
    parameter int IDXW   = 4,
    parameter int AW     = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_valid,
    input  logic [IDXW-1:0]   cap_idx,
    input  logic [DATA_W-1:0] cap_byte,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [DATA_W-1:0] ram_wdata
);

    typedef struct packed {
        logic              we;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] data;
    } wr_regs_t;

    wr_regs_t wr_d, wr_q;
    logic [AW-1:0] addr_ext;

    generate
        if (AW > IDXW) begin : g_pad
            assign addr_ext = {{(AW-IDXW){1'b0}}, cap_idx};
        end else begin : g_same
            assign addr_ext = cap_idx[AW-1:0];
        end
    endgenerate

    always_comb begin
        wr_d    = wr_q;
        wr_d.we = cap_valid;
        if (cap_valid) begin
            wr_d.addr = addr_ext;
            wr_d.data = cap_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
        end else begin
            wr_q <= wr_d;
        end
    end

    assign ram_we    = wr_q.we;
    assign ram_addr  = wr_q.addr;
    assign ram_wdata = wr_q.data;

endmodule

// File: rtl/brs_done_flag.sv
module brs_done_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic level
);

    logic level_d, level_q;

    always_comb begin
        level_d = level_q ^ flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end

    assign level = level_q;

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
    parameter int                  BURST_LEN = 14,
    parameter int                  RAM_DEPTH = 16,
    parameter int                  REG_W     = 8,
    parameter int                  DATA_W    = 8,
    parameter logic [REG_W-1:0]    BASE_REG  = 8'h3B,
    parameter bit                  CFG_EN    = 1'b1,
    parameter logic [REG_W-1:0]    CFG_REG   = 8'h6B,
    parameter logic [DATA_W-1:0]   CFG_VAL   = 8'h00,
    localparam int                 AW        = $clog2(RAM_DEPTH),
    localparam int                 IDXW      = $clog2(BURST_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [REG_W-1:0]  cmd_reg,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_ack_err,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              ram_we,
    output logic [AW-1:0]     ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              done_toggle
);

    logic              cap_valid;
    logic [IDXW-1:0]   cap_idx;
    logic [DATA_W-1:0] cap_byte;
    logic              burst_end;

    brs_fsm #(
        .BURST_LEN (BURST_LEN),
        .IDXW      (IDXW),
        .REG_W     (REG_W),
        .DATA_W    (DATA_W),
        .BASE_REG  (BASE_REG),
        .CFG_EN    (CFG_EN),
        .CFG_REG   (CFG_REG),
        .CFG_VAL   (CFG_VAL)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_write   (cmd_write),
        .cmd_reg     (cmd_reg),
        .cmd_wdata   (cmd_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_ack_err (rsp_ack_err),
        .rsp_data    (rsp_data),
        .cap_valid   (cap_valid),
        .cap_idx     (cap_idx),
        .cap_byte    (cap_byte),
        .burst_end   (burst_end)
    );

    brs_ram_port #(
        .IDXW   (IDXW),
        .AW     (AW),
        .DATA_W (DATA_W)
    ) u_ram_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_valid (cap_valid),
        .cap_idx   (cap_idx),
        .cap_byte  (cap_byte),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata)
    );

    brs_done_flag u_done (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (burst_end),
        .level (done_toggle)
    );

endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
    parameter int BURST_LEN = 14,
    parameter int REG_W     = 8,
    parameter int DATA_W    = 8,
    parameter int AW        = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              cmd_write,
    input logic [REG_W-1:0]  cmd_reg,
    input logic [DATA_W-1:0] cmd_wdata,
    input logic              rsp_valid,
    input logic              rsp_ack_err,
    input logic              ram_we,
    input logic [AW-1:0]     ram_addr,
    input logic              done_toggle
);

    // R9: an offered command is held until it is taken
    p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_reg)
                                    && $stable(cmd_write) && $stable(cmd_wdata));

    // R4: one command at a time, nothing offered right after a handshake
    p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_valid);

    // R5: writes only land inside the burst window
    p_addr_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_addr < AW'(BURST_LEN));

    // R8: every RAM write follows an acknowledged response
    p_write_needs_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(rsp_valid && !rsp_ack_err));

    // R6: the toggle moves only together with the last write of a burst
    p_toggle_on_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_toggle != $past(done_toggle) |-> ram_we && ram_addr == AW'(BURST_LEN - 1));

endmodule

bind burst_read_seq brs_checker #(
    .BURST_LEN (BURST_LEN),
    .REG_W     (REG_W),
    .DATA_W    (DATA_W),
    .AW        (AW)
) u_brs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_write   (cmd_write),
    .cmd_reg     (cmd_reg),
    .cmd_wdata   (cmd_wdata),
    .rsp_valid   (rsp_valid),
    .rsp_ack_err (rsp_ack_err),
    .ram_we      (ram_we),
    .ram_addr    (ram_addr),
    .done_toggle (done_toggle)
);

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;

    localparam int         BURST = 14;
    localparam logic [7:0] BASE  = 8'h3B;
    localparam logic [7:0] CREG  = 8'h6B;
    localparam logic [7:0] CVAL  = 8'h01;
    localparam int         WDOG  = 100000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, en;
    logic       cmd_valid, cmd_ready, cmd_write;
    logic [7:0] cmd_reg, cmd_wdata;
    logic       rsp_valid, rsp_ack_err;
    logic [7:0] rsp_data;
    logic       ram_we;
    logic [3:0] ram_addr;
    logic [7:0] ram_wdata;
    logic       done_toggle;

    burst_read_seq #(
        .BURST_LEN (BURST),
        .RAM_DEPTH (16),
        .REG_W     (8),
        .DATA_W    (8),
        .BASE_REG  (BASE),
        .CFG_EN    (1'b1),
        .CFG_REG   (CREG),
        .CFG_VAL   (CVAL)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_write   (cmd_write),
        .cmd_reg     (cmd_reg),
        .cmd_wdata   (cmd_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_ack_err (rsp_ack_err),
        .rsp_data    (rsp_data),
        .ram_we      (ram_we),
        .ram_addr    (ram_addr),
        .ram_wdata   (ram_wdata),
        .done_toggle (done_toggle)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // stimulus knobs (written only by the test process)
    int ready_mode = 0;
    int lat        = 0;
    int spur_cnt   = 0;
    int arm_req    = 0;

    // reference model state (written only by the monitor)
    int    hs_cnt = 0, err_hs = 1, arm_used = 0;
    int    idx = 0, cycles = 0, n_rd_hs = 0, n_err = 0, cyc = 0;
    bit    cfg_ok = 0, model_idle = 0, outstanding = 0, tmo = 0;
    bit    exp_we = 0, exp_done = 0, exp_cmdv_chk = 0, exp_cmdv = 0, prev_stall = 0;
    int    exp_addr = 0, exp_data = 0, prev_reg = 0;
    string exp_we_req = "R5", exp_cmdv_req = "R3", cfg_req = "R1", rd_req = "R4";

    // bus master model: drives just after each rising edge
    initial begin : bus_model
        int  hs_taken, cnt, spur_done, data_ctr;
        bit  pend, cur_err, tgl;
        hs_taken = 0; cnt = 0; spur_done = 0; data_ctr = 0;
        pend = 0; cur_err = 0; tgl = 0;
        cmd_ready = 1'b0; rsp_valid = 1'b0; rsp_ack_err = 1'b0; rsp_data = 8'h00;
        forever begin
            @(posedge clk);
            #1;
            rsp_valid   = 1'b0;
            rsp_ack_err = 1'b0;
            tgl         = ~tgl;
            cmd_ready   = (ready_mode == 0) ? 1'b1 : tgl;
            if (hs_cnt != hs_taken) begin
                hs_taken = hs_cnt;
                pend     = 1;
                cnt      = lat;
                cur_err  = (hs_taken == err_hs);
            end
            if (pend) begin
                if (cnt == 0) begin
                    data_ctr++;
                    rsp_valid   = 1'b1;
                    rsp_data    = 8'h90 ^ 8'(data_ctr * 37);
                    rsp_ack_err = cur_err;
                    pend        = 0;
                end else begin
                    cnt--;
                end
            end else if (spur_cnt != spur_done) begin
                spur_done = spur_cnt;
                rsp_valid = 1'b1;
                rsp_data  = 8'h5A;
            end
        end
    end

    // reference model and per-clock comparison, sampled on falling edges
    initial begin : monitor
        forever begin
            @(negedge clk);
            if (!rst_n) continue;
            cyc++;
            if (cyc == WDOG) begin
                tmo = 1;
                chk("watchdog", "run finished in time", 0, 1);
            end
            chk(exp_we_req, "ram_we", ram_we, exp_we);
            if (exp_we) begin
                chk("R5", "ram_addr", ram_addr, exp_addr);
                chk("R5", "ram_wdata", ram_wdata, exp_data);
            end
            chk("R6", "done_toggle", done_toggle, exp_done);
            if (exp_cmdv_chk) chk(exp_cmdv_req, "cmd_valid", cmd_valid, exp_cmdv);
            if (prev_stall) begin
                chk("R9", "cmd_valid held", cmd_valid, 1);
                chk("R9", "cmd_reg held", cmd_reg, prev_reg);
            end
            prev_stall = cmd_valid && !cmd_ready;
            prev_reg   = cmd_reg;

            exp_we       = 0;
            exp_we_req   = "R5";
            exp_cmdv_chk = 0;
            if (cfg_ok && model_idle) begin
                exp_cmdv_chk = 1;
                exp_cmdv     = en;
                exp_cmdv_req = "R3";
                if (en) model_idle = 0;
            end
            if (cmd_valid && cmd_ready) begin
                hs_cnt++;
                if (!cfg_ok) begin
                    chk(cfg_req, "config write flag", cmd_write, 1);
                    chk(cfg_req, "config register", cmd_reg, CREG);
                    chk(cfg_req, "config data", cmd_wdata, CVAL);
                end else begin
                    chk(rd_req, "read flag", cmd_write, 0);
                    chk(rd_req, "read register", cmd_reg, BASE + idx);
                    rd_req = "R4";
                    n_rd_hs++;
                    if (arm_req != arm_used && idx == 5) begin
                        arm_used++;
                        err_hs = hs_cnt;
                    end
                end
                outstanding = 1;
            end
            if (rsp_valid) begin
                if (!outstanding) begin
                    exp_we_req = "R10";
                end else begin
                    outstanding = 0;
                    if (!cfg_ok) begin
                        if (rsp_ack_err) begin
                            cfg_req = "R2";
                        end else begin
                            cfg_ok       = 1;
                            model_idle   = 1;
                            exp_cmdv_chk = 1;
                            exp_cmdv     = 0;
                            exp_cmdv_req = "R1";
                        end
                    end else if (rsp_ack_err) begin
                        exp_we_req   = "R8";
                        rd_req       = "R8";
                        idx          = 0;
                        model_idle   = 1;
                        exp_cmdv_chk = 1;
                        exp_cmdv     = 0;
                        exp_cmdv_req = "R8";
                        n_err++;
                    end else begin
                        exp_we   = 1;
                        exp_addr = idx;
                        exp_data = rsp_data;
                        if (idx == BURST - 1) begin
                            exp_done     = !exp_done;
                            cycles++;
                            idx          = 0;
                            exp_cmdv_chk = 1;
                            if (en) begin
                                exp_cmdv     = 1;
                                exp_cmdv_req = "R11";
                            end else begin
                                exp_cmdv     = 0;
                                exp_cmdv_req = "R7";
                                model_idle   = 1;
                            end
                        end else begin
                            idx++;
                        end
                    end
                end
            end
        end
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n && !tmo; i++) @(negedge clk);
    endtask

    task automatic wait_bursts(input int target);
        while (cycles < target && !tmo) @(negedge clk);
    endtask

    initial begin : test
        int c0, h0;
        rst_n = 1'b0;
        en    = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "cmd_valid in reset", cmd_valid, 0);
        chk("R1", "ram_we in reset", ram_we, 0);
        chk("R1", "done_toggle in reset", done_toggle, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // first config response fails, the retry succeeds, en stays low
        wait_clks(40);
        chk("R2", "config done after retry", cfg_ok, 1);
        chk("R3", "no read while en low", n_rd_hs, 0);

        // stray response while idle
        spur_cnt++;
        wait_clks(10);
        chk("R10", "no read after stray response", n_rd_hs, 0);

        // continuous bursts, fast bus
        @(posedge clk);
        #1 en = 1'b1;
        wait_bursts(2);

        // stalled handshake and slow responses
        ready_mode = 1;
        lat        = 3;
        wait_bursts(cycles + 2);

        // ack failure at read index 5
        arm_req++;
        while (n_err == 0 && !tmo) @(negedge clk);
        wait_bursts(cycles + 1);
        chk("R8", "ack failures seen", n_err, 1);

        // enable falls mid-burst
        lat = 1;
        while (!(idx == 6 && outstanding) && !tmo) @(negedge clk);
        @(posedge clk);
        #1 en = 1'b0;
        c0 = cycles;
        wait_bursts(c0 + 1);
        h0 = n_rd_hs;
        wait_clks(40);
        chk("R7", "no read after burst with en low", n_rd_hs, h0);
        chk("R7", "interrupted burst completed", cycles, c0 + 1);

        // single-cycle enable pulse starts exactly one burst
        @(posedge clk);
        #1 en = 1'b1;
        @(posedge clk);
        #1 en = 1'b0;
        wait_bursts(c0 + 2);
        wait_clks(40);
        chk("R3", "one burst per enable pulse", cycles, c0 + 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule